// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the host-side front end for configuration space accesses. It offers two windows to the host. The index window holds a 32-bit configuration address register. The data window accepts 1-, 2- or 4-byte reads and writes. The system fabric decodes a 4 KB region for each window and passes only the low three offset bits to the block. Data in both windows is little-endian: byte lane n carries bits 8n+7:8n.

Every data-window access turns the held index value and the low offset bits into a standard bus/device/function/register address. The block then issues exactly one request on a downstream configuration bus, which uses a valid/ready handshake. A read completes when that bus returns response data, and the addressed bytes are handed back to the host. The index register accepts three formats:

- a raw format, marked by bit 31 set;
- a type-1 format, marked by bit 0 set;
- a type-0 format, in which a one-hot select bit gives the device number as its bit position.

The block also merges four interrupt pins from each downstream slot onto four shared outputs. The pin index is rotated by the slot number.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset the index register reads as zero, and a word written to it through the index window reads back unchanged.
- R2: An index-window write updates only the byte lanes selected by the size and offset. Size code 0 is one byte, code 1 is two bytes and code 2 is four bytes. The lanes start at offset bits 1:0, and host write data is right-aligned.
- R3: With index bit 31 set, the request address is the index value ORed with offset bits 1:0 in address bits 1:0.
- R4: With index bit 31 clear and bit 0 set, the request address is index bits 31:3 followed by offset bits 2:0.
- R5: With index bits 31 and 0 both clear, the request address is built as follows:
  - bits 31:16 are zero;
  - bits 15:11 hold the position of the lowest set index bit within 31:11;
  - bits 10:8 are index bits 10:8;
  - bits 7:3 are index bits 7:3;
  - bits 2:0 are offset bits 2:0.
- R6: In that one-hot format, when no index bit in 31:11 is set, address bits 15:11 are all ones (device 31).
- R7: Request byte enables are computed from the size and offset:
  - one byte gives 0001 shifted left by offset bits 1:0;
  - two bytes give 0011 shifted left by offset bits 1:0;
  - four bytes give 1111.
  Request write data is host write data shifted left by 8 times offset bits 1:0.
- R8: The request stays valid, with address, enables, data and direction unchanged, until the cycle in which ready is high.
- R9: Read data returned to the host is the response shifted right by 8 times offset bits 1:0, then masked to the access size.
- R10: Interrupt output k is high when some slot d has pin p high with (p + d) mod 4 = k. Slot d drives devIrq bits 4d+3:4d.
- R11: Each data access issues exactly one request and each index access issues none. Completion is a one-cycle done pulse, given the cycle after acceptance for writes and the cycle after the response for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access pending; held until hostDone |
| hostWindow | input | 1 | 0 selects the index window, 1 the data window |
| hostWrite | input | 1 | 1 for write, 0 for read |
| hostOffset | input | 3 | Low offset bits within the window |
| hostSize | input | 2 | 0 byte, 1 half-word, 2 word |
| hostWdata | input | 32 | Right-aligned write data |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Right-aligned read data, valid with hostDone |
| cfgReqValid | output | 1 | Configuration request valid |
| cfgReqReady | input | 1 | Configuration bus accepts the request |
| cfgReqAddr | output | 32 | Translated configuration address |
| cfgReqWrite | output | 1 | Request direction |
| cfgReqBe | output | 4 | Byte enables |
| cfgReqWdata | output | 32 | Lane-aligned write data |
| cfgRspValid | input | 1 | Read response valid |
| cfgRspData | input | 32 | Lane-aligned read response |
| devIrq | input | 4*NumSlots | Per-slot interrupt pins |
| irqOut | output | 4 | Shared interrupt outputs |

## Verification
The index values are drawn randomly from the three formats, so a fault in the format selection or in any one field mapping shows up as a wrong address.

Some one-hot indices have extra set bits above the select bit, which separates a lowest-bit search from a highest-bit one. An index with no select bit present checks the all-ones device case.

Random sizes, aligned offsets, request stalls and response delays check the lane shifting and the handshake hold. Single-pin and mixed interrupt vectors check that each rotation lands on its own output.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic idxWrite;
    logic idxRead;
    logic reqLoad;
    logic rspCapture;
  } ctrlStrobe_t;

  function automatic logic [3:0] laneEnables(input logic [1:0] size, input logic [1:0] off);
    case (size)
      SZ_BYTE: return 4'b0001 << off;
      SZ_HALF: return 4'b0011 << off;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] sizeMask(input logic [1:0] size);
    case (size)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/pcfg_xlate.sv
module pcfg_xlate #(
  parameter int IdselLow = 11
) (
  input  logic [31:0] idx,
  input  logic [2:0]  off,
  output logic [31:0] addr
);
  localparam int DevW = 5;

  logic [DevW-1:0] devNum;

  // Lowest set bit in idx[31:IdselLow] wins; none set gives all ones
  always_comb begin
    devNum = '1;
    for (int i = 31; i >= IdselLow; i--) begin
      if (idx[i]) devNum = DevW'(i);
    end
  end

  always_comb begin
    if (idx[31]) begin
      addr = idx | {30'd0, off[1:0]};
    end else if (idx[0]) begin
      addr = {idx[31:3], off};
    end else begin
      addr = {16'd0, devNum, idx[10:8], idx[7:3], off};
    end
  end
endmodule

// File: rtl/pcfg_irq_swizzle.sv
module pcfg_irq_swizzle #(
  parameter int NumSlots = 32
) (
  input  logic [NumSlots*4-1:0] devIrq,
  output logic [3:0]            irqOut
);
  localparam int NumLines = 4;

  for (genvar k = 0; k < NumLines; k++) begin : g_line
    logic [NumSlots-1:0] term;
    for (genvar d = 0; d < NumSlots; d++) begin : g_slot
      localparam int Pin = (k + NumLines - (d % NumLines)) % NumLines;
      assign term[d] = devIrq[d*NumLines + Pin];
    end
    assign irqOut[k] = |term;
  end
endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
  import pcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWindow,
  input  logic        hostWrite,
  input  logic        cfgReqReady,
  input  logic        cfgRspValid,
  output ctrlStrobe_t strobe,
  output logic        cfgReqValid,
  output logic        hostDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_DONE} state_e;

  state_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (hostValid) begin
          if (!hostWindow) begin
            strobe.idxWrite = hostWrite;
            strobe.idxRead  = !hostWrite;
            nextState       = ST_DONE;
          end else begin
            strobe.reqLoad = 1'b1;
            nextState      = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (cfgReqReady) nextState = hostWrite ? ST_DONE : ST_RSP;
      end
      ST_RSP: begin
        if (cfgRspValid) begin
          strobe.rspCapture = 1'b1;
          nextState         = ST_DONE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign cfgReqValid = (state == ST_REQ);
  assign hostDone    = (state == ST_DONE);
endmodule

// File: rtl/pcfg_dpath.sv
module pcfg_dpath
  import pcfg_pkg::*;
#(
  parameter int IdselLow = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        hostWrite,
  input  logic [2:0]  hostOffset,
  input  logic [1:0]  hostSize,
  input  logic [31:0] hostWdata,
  input  logic [31:0] cfgRspData,
  output logic [31:0] cfgReqAddr,
  output logic        cfgReqWrite,
  output logic [3:0]  cfgReqBe,
  output logic [31:0] cfgReqWdata,
  output logic [31:0] hostRdata
);
  localparam int Lanes = 4;

  logic [31:0] idxReg;
  logic [31:0] xAddr;
  logic [31:0] laneData;
  logic [3:0]  laneBe;
  logic [1:0]  laneShift;
  logic [1:0]  rdShift;
  logic [1:0]  rdSize;

  assign laneShift = hostOffset[1:0];
  assign laneBe    = laneEnables(hostSize, laneShift);
  assign laneData  = hostWdata << {laneShift, 3'b000};

  pcfg_xlate #(.IdselLow(IdselLow)) u_xlate (
    .idx  (idxReg),
    .off  (hostOffset),
    .addr (xAddr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg      <= '0;
      cfgReqAddr  <= '0;
      cfgReqWrite <= 1'b0;
      cfgReqBe    <= '0;
      cfgReqWdata <= '0;
      hostRdata   <= '0;
      rdShift     <= '0;
      rdSize      <= '0;
    end else begin
      if (strobe.idxWrite) begin
        for (int i = 0; i < Lanes; i++) begin
          if (laneBe[i]) idxReg[8*i +: 8] <= laneData[8*i +: 8];
        end
      end
      if (strobe.idxRead) begin
        hostRdata <= (idxReg >> {laneShift, 3'b000}) & sizeMask(hostSize);
      end
      if (strobe.reqLoad) begin
        cfgReqAddr  <= xAddr;
        cfgReqWrite <= hostWrite;
        cfgReqBe    <= laneBe;
        cfgReqWdata <= laneData;
        rdShift     <= laneShift;
        rdSize      <= hostSize;
      end
      if (strobe.rspCapture) begin
        hostRdata <= (cfgRspData >> {rdShift, 3'b000}) & sizeMask(rdSize);
      end
    end
  end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pcfg_pkg::*;
#(
  parameter int NumSlots = 32,
  parameter int IdselLow = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostValid,
  input  logic                  hostWindow,
  input  logic                  hostWrite,
  input  logic [2:0]            hostOffset,
  input  logic [1:0]            hostSize,
  input  logic [31:0]           hostWdata,
  output logic                  hostDone,
  output logic [31:0]           hostRdata,
  output logic                  cfgReqValid,
  input  logic                  cfgReqReady,
  output logic [31:0]           cfgReqAddr,
  output logic                  cfgReqWrite,
  output logic [3:0]            cfgReqBe,
  output logic [31:0]           cfgReqWdata,
  input  logic                  cfgRspValid,
  input  logic [31:0]           cfgRspData,
  input  logic [NumSlots*4-1:0] devIrq,
  output logic [3:0]            irqOut
);
  ctrlStrobe_t strobe;

  pcfg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostValid   (hostValid),
    .hostWindow  (hostWindow),
    .hostWrite   (hostWrite),
    .cfgReqReady (cfgReqReady),
    .cfgRspValid (cfgRspValid),
    .strobe      (strobe),
    .cfgReqValid (cfgReqValid),
    .hostDone    (hostDone)
  );

  pcfg_dpath #(.IdselLow(IdselLow)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostWrite   (hostWrite),
    .hostOffset  (hostOffset),
    .hostSize    (hostSize),
    .hostWdata   (hostWdata),
    .cfgRspData  (cfgRspData),
    .cfgReqAddr  (cfgReqAddr),
    .cfgReqWrite (cfgReqWrite),
    .cfgReqBe    (cfgReqBe),
    .cfgReqWdata (cfgReqWdata),
    .hostRdata   (hostRdata)
  );

  pcfg_irq_swizzle #(.NumSlots(NumSlots)) u_swz (
    .devIrq (devIrq),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk #(
  parameter int NumSlots = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  hostValid,
  input logic                  hostWindow,
  input logic                  hostDone,
  input logic                  cfgReqValid,
  input logic                  cfgReqReady,
  input logic [31:0]           cfgReqAddr,
  input logic                  cfgReqWrite,
  input logic [3:0]            cfgReqBe,
  input logic [31:0]           cfgReqWdata,
  input logic [NumSlots*4-1:0] devIrq,
  input logic [3:0]            irqOut
);
  // R8: a stalled request holds all of its fields
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && !cfgReqReady |=> cfgReqValid && $stable(cfgReqAddr) && $stable(cfgReqBe)
      && $stable(cfgReqWdata) && $stable(cfgReqWrite));

  // R7: enables cover one, two or four lanes
  p_be_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> ($countones(cfgReqBe) == 1 || $countones(cfgReqBe) == 2 || $countones(cfgReqBe) == 4));

  // R11: an accepted write completes on the next cycle
  p_write_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && cfgReqReady && cfgReqWrite |=> hostDone && !cfgReqValid);

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  // R11: an index access raises no request
  p_idx_no_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && !hostWindow && !cfgReqValid && !hostDone |=> !cfgReqValid);

  // R10: no pin high means no output high
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (devIrq == '0) |-> (irqOut == 4'd0));
endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk #(.NumSlots(NumSlots)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostValid   (hostValid),
  .hostWindow  (hostWindow),
  .hostDone    (hostDone),
  .cfgReqValid (cfgReqValid),
  .cfgReqReady (cfgReqReady),
  .cfgReqAddr  (cfgReqAddr),
  .cfgReqWrite (cfgReqWrite),
  .cfgReqBe    (cfgReqBe),
  .cfgReqWdata (cfgReqWdata),
  .devIrq      (devIrq),
  .irqOut      (irqOut)
);

// File: tb/pci_cfg_xlate_tb_top.sv
`timescale 1ns/1ps
module pci_cfg_xlate_tb_top;
  localparam int NumSlots = 32;

  logic                  clk = 1'b0;
  logic                  rstN;
  logic                  hostValid, hostWindow, hostWrite;
  logic [2:0]            hostOffset;
  logic [1:0]            hostSize;
  logic [31:0]           hostWdata;
  logic                  hostDone;
  logic [31:0]           hostRdata;
  logic                  cfgReqValid, cfgReqReady, cfgReqWrite, cfgRspValid;
  logic [31:0]           cfgReqAddr, cfgReqWdata, cfgRspData;
  logic [3:0]            cfgReqBe;
  logic [NumSlots*4-1:0] devIrq;
  logic [3:0]            irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;
  logic [31:0] idxModel = '0;

  always #5 clk = ~clk;

  pci_cfg_xlate #(.NumSlots(NumSlots)) dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWindow(hostWindow),
    .hostWrite(hostWrite), .hostOffset(hostOffset), .hostSize(hostSize),
    .hostWdata(hostWdata), .hostDone(hostDone), .hostRdata(hostRdata),
    .cfgReqValid(cfgReqValid), .cfgReqReady(cfgReqReady), .cfgReqAddr(cfgReqAddr),
    .cfgReqWrite(cfgReqWrite), .cfgReqBe(cfgReqBe), .cfgReqWdata(cfgReqWdata),
    .cfgRspValid(cfgRspValid), .cfgRspData(cfgRspData), .devIrq(devIrq), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [31:0] idx, input logic [2:0] off);
    logic [4:0] dev;
    if (idx[31]) return idx | {30'd0, off[1:0]};          // R3
    if (idx[0]) return {idx[31:3], off};                   // R4
    dev = 5'h1F;                                           // R6
    for (int i = 11; i < 32; i++) begin
      if (idx[i]) begin
        dev = 5'(i);
        break;
      end
    end
    return {16'd0, dev, idx[10:8], idx[7:3], off};         // R5
  endfunction

  function automatic logic [3:0] expBe(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 4'(1 << off);
    if (sz == 2'd1) return 4'(3 << off);
    return 4'hF;
  endfunction

  function automatic logic [31:0] expMask(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] expIrq(input logic [NumSlots*4-1:0] v);
    logic [3:0] r = '0;
    for (int d = 0; d < NumSlots; d++)
      for (int p = 0; p < 4; p++)
        if (v[d*4+p]) r[(p+d)%4] = 1'b1;
    return r;
  endfunction

  task automatic idxAccess(input bit wr, input logic [2:0] off, input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] lanes;
    logic [3:0]  be;
    @(negedge clk);
    hostValid = 1'b1; hostWindow = 1'b0; hostWrite = wr;
    hostOffset = off; hostSize = sz; hostWdata = wd;
    @(negedge clk);
    check(hostDone === 1'b1, "R11 index done", 128'(hostDone), 128'(1));
    check(cfgReqValid === 1'b0, "R11 index no request", 128'(cfgReqValid), 128'(0));
    if (!wr) begin
      check(hostRdata === ((idxModel >> (8*off[1:0])) & expMask(sz)), "R1 index readback",
            128'(hostRdata), 128'((idxModel >> (8*off[1:0])) & expMask(sz)));
    end else begin
      lanes = wd << (8*off[1:0]);
      be = expBe(sz, off[1:0]);
      for (int i = 0; i < 4; i++) if (be[i]) idxModel[8*i +: 8] = lanes[8*i +: 8];
    end
    hostValid = 1'b0;
  endtask

  task automatic dataAccess(input bit wr, input logic [2:0] off, input logic [1:0] sz,
                            input logic [31:0] wd, input logic [31:0] rsp, input int stall, input int rdly);
    logic [31:0] ea;
    logic [31:0] er;
    ea = expAddr(idxModel, off);
    @(negedge clk);
    hostValid = 1'b1; hostWindow = 1'b1; hostWrite = wr;
    hostOffset = off; hostSize = sz; hostWdata = wd;
    @(negedge clk);
    check(cfgReqValid === 1'b1, "R11 request issued", 128'(cfgReqValid), 128'(1));
    check(cfgReqAddr === ea, "R3 R4 R5 R6 address", 128'(cfgReqAddr), 128'(ea));
    check(cfgReqBe === expBe(sz, off[1:0]), "R7 byte enables", 128'(cfgReqBe), 128'(expBe(sz, off[1:0])));
    check(cfgReqWrite === wr, "R7 direction", 128'(cfgReqWrite), 128'(wr));
    if (wr) check(cfgReqWdata === (wd << (8*off[1:0])), "R7 write lanes",
                  128'(cfgReqWdata), 128'(wd << (8*off[1:0])));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(cfgReqValid === 1'b1 && cfgReqAddr === ea, "R8 hold under stall",
            128'({cfgReqValid, cfgReqAddr}), 128'({1'b1, ea}));
    end
    cfgReqReady = 1'b1;
    @(negedge clk);
    cfgReqReady = 1'b0;
    check(cfgReqValid === 1'b0, "R11 single request", 128'(cfgReqValid), 128'(0));
    if (!wr) begin
      for (int s = 0; s < rdly; s++) begin
        check(hostDone === 1'b0, "R11 read waits for response", 128'(hostDone), 128'(0));
        @(negedge clk);
      end
      cfgRspValid = 1'b1; cfgRspData = rsp;
      @(negedge clk);
      cfgRspValid = 1'b0; cfgRspData = $urandom;
      er = (rsp >> (8*off[1:0])) & expMask(sz);
      check(hostRdata === er, "R9 read data", 128'(hostRdata), 128'(er));
    end
    check(hostDone === 1'b1, "R11 data done", 128'(hostDone), 128'(1));
    hostValid = 1'b0;
  endtask

  function automatic logic [31:0] randIdx();
    int fmt = $urandom % 3;
    logic [31:0] r = $urandom;
    int dev;
    logic [31:0] above;
    if (fmt == 0) return {1'b1, r[30:0]};
    if (fmt == 1) return {1'b0, r[30:1], 1'b1};
    dev = 11 + ($urandom % 20);
    above = ($urandom & 32'h7FFF_FFFF) & ~((32'd2 << dev) - 1);
    return above | (32'd1 << dev) | {21'd0, r[10:1], 1'b0};
  endfunction

  task automatic randSzOff(output logic [1:0] sz, output logic [2:0] off);
    sz = 2'($urandom % 3);
    off = 3'($urandom);
    if (sz == 2'd1) off[0] = 1'b0;
    if (sz == 2'd2) off[1:0] = 2'b00;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [1:0] sz;
    logic [2:0] off;
    logic [NumSlots*4-1:0] iv;
    void'($urandom(32'd20240611));
    rstN = 1'b0; hostValid = 1'b0; hostWindow = 1'b0; hostWrite = 1'b0;
    hostOffset = '0; hostSize = '0; hostWdata = '0;
    cfgReqReady = 1'b0; cfgRspValid = 1'b0; cfgRspData = '0; devIrq = '0;
    repeat (3) @(negedge clk);
    check(cfgReqValid === 1'b0 && hostDone === 1'b0, "R11 reset idle",
          128'({cfgReqValid, hostDone}), 128'(0));
    rstN = 1'b1;

    // R1: reset value, then word write/readback
    idxAccess(1'b0, 3'd0, 2'd2, 32'd0);
    idxAccess(1'b1, 3'd0, 2'd2, 32'hA5C3_0F81);
    idxAccess(1'b0, 3'd0, 2'd2, 32'd0);
    // R2: byte and half writes into the index register
    idxAccess(1'b1, 3'd2, 2'd0, 32'h0000_0077);
    idxAccess(1'b1, 3'd0, 2'd1, 32'h0000_BEEF);
    idxAccess(1'b0, 3'd0, 2'd2, 32'd0);
    idxAccess(1'b0, 3'd3, 2'd0, 32'd0);

    // R3 directed: raw format OR of low bits
    idxAccess(1'b1, 3'd0, 2'd2, 32'h8000_0003);
    dataAccess(1'b0, 3'd2, 2'd0, 32'd0, 32'h11223344, 0, 0);
    // R4 directed
    idxAccess(1'b1, 3'd0, 2'd2, 32'h00AB_CD07);
    dataAccess(1'b1, 3'd5, 2'd0, 32'h0000_005A, 32'd0, 1, 0);
    // R5 directed: select bit 11 plus higher bit 20 -> device 11
    idxAccess(1'b1, 3'd0, 2'd2, 32'h0010_0A7C);
    dataAccess(1'b0, 3'd4, 2'd2, 32'd0, 32'hCAFE_F00D, 2, 3);
    // R6 directed: no select bit -> device 31
    idxAccess(1'b1, 3'd0, 2'd2, 32'h0000_03F4);
    dataAccess(1'b0, 3'd6, 2'd1, 32'd0, 32'h1234_5678, 0, 1);

    // Random mix
    for (int n = 0; n < 150; n++) begin
      idxAccess(1'b1, 3'd0, 2'd2, randIdx());
      if (($urandom % 4) == 0) idxAccess(1'b0, 3'd0, 2'd2, 32'd0);
      randSzOff(sz, off);
      dataAccess(1'($urandom), off, sz, $urandom, $urandom, $urandom % 3, $urandom % 3);
    end

    // R10: single pins, then random vectors
    devIrq = '0;
    #1;
    check(irqOut === 4'd0, "R10 quiet", 128'(irqOut), 128'(0));
    for (int d = 0; d < NumSlots; d++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        devIrq = '0;
        devIrq[d*4+p] = 1'b1;
        #1;
        check(irqOut === expIrq(devIrq), "R10 single pin", 128'(irqOut), 128'(expIrq(devIrq)));
      end
    end
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      iv = '0;
      for (int b = 0; b < 3; b++) iv[$urandom % (NumSlots*4)] = 1'b1;
      devIrq = iv;
      #1;
      check(irqOut === expIrq(iv), "R10 mixed pins", 128'(irqOut), 128'(expIrq(iv)));
    end

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule